// File: doc/BRIEF.md
# Multiply-Accumulate Unit with 48-bit Accumulator

This block is a fixed-latency multiply-accumulate engine. It is built around one signed 24x24 multiplier and a 48-bit two's-complement accumulator. A host issues one command at a time on a small command port. The block raises `busy` for a fixed number of clocks that depends on the command. On the last busy clock it pulses `done`, and the result of the command takes effect at the clock edge that ends that cycle.

The block supports seven commands:

- clear the accumulator;
- load it from a 32-bit value (sign-extended) or from a 48-bit value;
- copy its low 32 bits or all 48 bits to the store port;
- add one product of two 32-bit register operands;
- add a three-term dot product of 16-bit lanes. The three lanes share the multiplier and take two clocks per lane.

Sums that leave the signed 48-bit range wrap around and set a sticky overflow flag.

The sequencer is a state machine with eight states. `IDLE` waits for a command. `CLEAR`, `LOAD32`, `LOAD48`, `STORE32`, `STORE48`, `MAC` and `DOT` each count down a cycle counter loaded on entry. The transitions are:

- **accept**: `IDLE` to the state named by the opcode, when `cmd_valid` is high with a defined opcode.
- **stay**: remain in the state while the counter is non-zero.
- **finish**: return to `IDLE` when the counter reaches zero. `done` is high during that cycle.

Reserved opcodes leave the machine in `IDLE`.

Top module: `mac_accum_unit`

## Requirements
- R1: While `rst_n` is low, `busy`, `done` and `ovf_flag` are 0, and `store_data` and the accumulator are 0.
- R2: Opcodes are 0 clear, 1 load32, 2 load48, 3 store32, 4 store48, 5 mac, 6 dot. When `cmd_valid` is high while `busy` is low and the opcode is 0 to 6, `busy` is high from the next clock. Opcode 7 is ignored and `busy` stays low.
- R3: `busy` stays high for exactly 4 (clear), 9 (either load), 7 (store32), 11 (store48), 8 (mac) or 6 (dot) clocks. `done` is high only in the last of those clocks.
- R4: A command presented while `busy` is high, including during the `done` cycle, is ignored. It changes neither the latency nor the accumulator.
- R5: Clear sets the accumulator to 0 and clears `ovf_flag`.
- R6: Load32 sets the accumulator to `load_data[31:0]` sign-extended to 48 bits. Load48 sets it to `load_data[47:0]`. Both clear `ovf_flag`.
- R7: Store32 sets `store_data` to zero in bits 47:32 and the accumulator's bits 31:0 in bits 31:0. Store48 sets `store_data` to the full accumulator. `store_data` changes at no other time.
- R8: Mac adds the signed product of `opnd_a[31:8]` and `opnd_b[31:8]` (24-bit signed each) to the accumulator.
- R9: Dot adds, lane by lane for i = 0, 1, 2, the signed product of `dot_x[16i+15:16i]` and `dot_y[16i+15:16i]` to the accumulator.
- R10: Every addition wraps modulo 2^48. Any addition whose signed result leaves the 48-bit range sets `ovf_flag`. The flag then stays set until a clear or a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 3 | Opcode |
| opnd_a | input | 32 | Mac operand A |
| opnd_b | input | 32 | Mac operand B |
| dot_x | input | 48 | Three 16-bit dot lanes, X side |
| dot_y | input | 48 | Three 16-bit dot lanes, Y side |
| load_data | input | 48 | Load value |
| busy | output | 1 | Command in progress |
| done | output | 1 | Last cycle of a command |
| store_data | output | 48 | Store port |
| ovf_flag | output | 1 | Sticky accumulator overflow |

## Verification
The bench counts busy cycles for every opcode. A wrong counter preload shows up as a latency off by one, and a `done` that comes early or twice is caught because the bench counts every `done` pulse inside each command.

It loads a negative 32-bit value and reads it back. A load that zero-extends, or a store32 that leaks the upper bits, gives the wrong 48-bit pattern.

Commands injected mid-run and on the `done` cycle are checked by reading the accumulator back afterwards, which exposes a sequencer that accepts while busy.

A positive accumulator pushed past the 48-bit limit by a mac, followed by a harmless mac and a clear, catches three faults: a flag that is not sticky, an adder that saturates instead of wrapping, and a clear that leaves the flag set.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [2:0] {
        OP_CLEAR   = 3'd0,
        OP_LOAD32  = 3'd1,
        OP_LOAD48  = 3'd2,
        OP_STORE32 = 3'd3,
        OP_STORE48 = 3'd4,
        OP_MAC     = 3'd5,
        OP_DOT     = 3'd6,
        OP_RSVD    = 3'd7
    } mac_op_e;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_CLEAR   = 3'd1,
        S_LOAD32  = 3'd2,
        S_LOAD48  = 3'd3,
        S_STORE32 = 3'd4,
        S_STORE48 = 3'd5,
        S_MAC     = 3'd6,
        S_DOT     = 3'd7
    } mac_state_e;

endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
    parameter int W = 24
) (
    input  logic signed [W-1:0]   mul_a,
    input  logic signed [W-1:0]   mul_b,
    output logic signed [2*W-1:0] mul_p
);
    assign mul_p = mul_a * mul_b;
endmodule

// File: rtl/mac_seq.sv
module mac_seq
    import mac_pkg::*;
#(
    parameter int LAT_CLEAR = 4,
    parameter int LAT_LOAD  = 9,
    parameter int LAT_ST32  = 7,
    parameter int LAT_ST48  = 11,
    parameter int LAT_MAC   = 8,
    parameter int LANES     = 3,
    parameter int SEL_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    output mac_state_e       state,
    output logic             busy,
    output logic             done,
    output logic             accept,
    output logic             commit,
    output logic [SEL_W-1:0] step_sel
);
    localparam int STEP_CYC = 2;
    localparam int LAT_DOT  = LANES * STEP_CYC;
    localparam int MAX_LAT  = (LAT_ST48 > LAT_LOAD) ? LAT_ST48 : LAT_LOAD;
    localparam int CNT_W    = $clog2(MAX_LAT + 1);
    localparam logic [CNT_W-1:0] DOT_LAST = CNT_W'(LAT_DOT - 1);

    mac_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] elapsed;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // transitions: accept, stay, finish
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (mac_op_e'(cmd_op))
                        OP_CLEAR:   begin state_d = S_CLEAR;   cnt_d = CNT_W'(LAT_CLEAR - 1); end
                        OP_LOAD32:  begin state_d = S_LOAD32;  cnt_d = CNT_W'(LAT_LOAD - 1);  end
                        OP_LOAD48:  begin state_d = S_LOAD48;  cnt_d = CNT_W'(LAT_LOAD - 1);  end
                        OP_STORE32: begin state_d = S_STORE32; cnt_d = CNT_W'(LAT_ST32 - 1);  end
                        OP_STORE48: begin state_d = S_STORE48; cnt_d = CNT_W'(LAT_ST48 - 1);  end
                        OP_MAC:     begin state_d = S_MAC;     cnt_d = CNT_W'(LAT_MAC - 1);   end
                        OP_DOT:     begin state_d = S_DOT;     cnt_d = DOT_LAST;              end
                        OP_RSVD:    begin state_d = S_IDLE;                                   end
                    endcase
                end
            end
            S_CLEAR, S_LOAD32, S_LOAD48, S_STORE32, S_STORE48, S_MAC, S_DOT: begin
                if (cnt_q == '0) begin
                    state_d = S_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        state    = state_q;
        busy     = (state_q != S_IDLE);
        done     = busy && (cnt_q == '0);
        accept   = (state_q == S_IDLE) && cmd_valid && (mac_op_e'(cmd_op) != OP_RSVD);
        elapsed  = DOT_LAST - cnt_q;
        step_sel = SEL_W'(elapsed >> 1);
        unique case (state_q)
            S_IDLE:  commit = 1'b0;
            S_DOT:   commit = elapsed[0];
            default: commit = (cnt_q == '0);
        endcase
    end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
    import mac_pkg::*;
#(
    parameter int MUL_W  = 24,
    parameter int OPND_W = 32,
    parameter int LANE_W = 16,
    parameter int LANES  = 3,
    parameter int SEL_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  mac_state_e              state,
    input  logic                    accept,
    input  logic                    commit,
    input  logic [SEL_W-1:0]        step_sel,
    input  logic [OPND_W-1:0]       opnd_a,
    input  logic [OPND_W-1:0]       opnd_b,
    input  logic [LANES*LANE_W-1:0] dot_x,
    input  logic [LANES*LANE_W-1:0] dot_y,
    input  logic [2*MUL_W-1:0]      load_data,
    output logic [2*MUL_W-1:0]      store_data,
    output logic                    ovf_flag
);
    localparam int ACC_W = 2 * MUL_W;
    localparam int VEC_W = LANES * LANE_W;

    logic [MUL_W-1:0]  lat_a, lat_b;
    logic [VEC_W-1:0]  lat_x, lat_y;
    logic [ACC_W-1:0]  lat_ld;
    logic [ACC_W-1:0]  acc_q;
    logic [LANE_W-1:0] lane_x, lane_y;
    logic [MUL_W-1:0]  mul_a, mul_b;
    logic [ACC_W-1:0]  prod;
    logic [ACC_W-1:0]  sum;
    logic              add_ovf;
    logic              unused_low;

    assign unused_low = ^{opnd_a[OPND_W-MUL_W-1:0], opnd_b[OPND_W-MUL_W-1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_a  <= '0;
            lat_b  <= '0;
            lat_x  <= '0;
            lat_y  <= '0;
            lat_ld <= '0;
        end else if (accept) begin
            lat_a  <= opnd_a[OPND_W-1 -: MUL_W];
            lat_b  <= opnd_b[OPND_W-1 -: MUL_W];
            lat_x  <= dot_x;
            lat_y  <= dot_y;
            lat_ld <= load_data;
        end
    end

    always_comb begin
        lane_x = '0;
        lane_y = '0;
        for (int i = 0; i < LANES; i++) begin
            if (step_sel == SEL_W'(i)) begin
                lane_x = lat_x[i*LANE_W +: LANE_W];
                lane_y = lat_y[i*LANE_W +: LANE_W];
            end
        end
    end

    always_comb begin
        if (state == S_DOT) begin
            mul_a = {{(MUL_W-LANE_W){lane_x[LANE_W-1]}}, lane_x};
            mul_b = {{(MUL_W-LANE_W){lane_y[LANE_W-1]}}, lane_y};
        end else begin
            mul_a = lat_a;
            mul_b = lat_b;
        end
    end

    mac_mul #(.W(MUL_W)) u_mul (
        .mul_a (mul_a),
        .mul_b (mul_b),
        .mul_p (prod)
    );

    assign sum     = acc_q + prod;
    assign add_ovf = (acc_q[ACC_W-1] == prod[ACC_W-1]) && (sum[ACC_W-1] != acc_q[ACC_W-1]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q      <= '0;
            store_data <= '0;
            ovf_flag   <= 1'b0;
        end else if (commit) begin
            unique case (state)
                S_CLEAR: begin
                    acc_q    <= '0;
                    ovf_flag <= 1'b0;
                end
                S_LOAD32: begin
                    acc_q    <= {{(ACC_W-OPND_W){lat_ld[OPND_W-1]}}, lat_ld[OPND_W-1:0]};
                    ovf_flag <= 1'b0;
                end
                S_LOAD48: begin
                    acc_q    <= lat_ld;
                    ovf_flag <= 1'b0;
                end
                S_STORE32: store_data <= {{(ACC_W-OPND_W){1'b0}}, acc_q[OPND_W-1:0]};
                S_STORE48: store_data <= acc_q;
                S_MAC, S_DOT: begin
                    acc_q    <= sum;
                    ovf_flag <= ovf_flag | add_ovf;
                end
                S_IDLE: ;
            endcase
        end
    end

endmodule

// File: rtl/mac_accum_unit.sv
module mac_accum_unit
    import mac_pkg::*;
#(
    parameter int MUL_W     = 24,
    parameter int OPND_W    = 32,
    parameter int LANE_W    = 16,
    parameter int LANES     = 3,
    parameter int LAT_CLEAR = 4,
    parameter int LAT_LOAD  = 9,
    parameter int LAT_ST32  = 7,
    parameter int LAT_ST48  = 11,
    parameter int LAT_MAC   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [2:0]              cmd_op,
    input  logic [OPND_W-1:0]       opnd_a,
    input  logic [OPND_W-1:0]       opnd_b,
    input  logic [LANES*LANE_W-1:0] dot_x,
    input  logic [LANES*LANE_W-1:0] dot_y,
    input  logic [2*MUL_W-1:0]      load_data,
    output logic                    busy,
    output logic                    done,
    output logic [2*MUL_W-1:0]      store_data,
    output logic                    ovf_flag
);
    localparam int SEL_W = $clog2(LANES);

    mac_state_e       state;
    logic             accept;
    logic             commit;
    logic [SEL_W-1:0] step_sel;

    mac_seq #(
        .LAT_CLEAR (LAT_CLEAR),
        .LAT_LOAD  (LAT_LOAD),
        .LAT_ST32  (LAT_ST32),
        .LAT_ST48  (LAT_ST48),
        .LAT_MAC   (LAT_MAC),
        .LANES     (LANES),
        .SEL_W     (SEL_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .state     (state),
        .busy      (busy),
        .done      (done),
        .accept    (accept),
        .commit    (commit),
        .step_sel  (step_sel)
    );

    mac_datapath #(
        .MUL_W  (MUL_W),
        .OPND_W (OPND_W),
        .LANE_W (LANE_W),
        .LANES  (LANES),
        .SEL_W  (SEL_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .state      (state),
        .accept     (accept),
        .commit     (commit),
        .step_sel   (step_sel),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .dot_x      (dot_x),
        .dot_y      (dot_y),
        .load_data  (load_data),
        .store_data (store_data),
        .ovf_flag   (ovf_flag)
    );

endmodule

// File: rtl/mac_accum_unit_chk.sv
module mac_accum_unit_chk #(
    parameter int ACC_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic             busy,
    input logic             done,
    input logic [ACC_W-1:0] store_data,
    input logic             ovf_flag
);
    always_comb begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (!busy && !done && !ovf_flag);
        end
    end

    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_op != 3'd7) |=> busy);

    a_r2_rsvd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && cmd_op != 3'd7)) |=> !busy);

    a_r3_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r3_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r7_store_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(store_data));

    a_r10_ovf_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> $past(busy));

endmodule

bind mac_accum_unit mac_accum_unit_chk #(.ACC_W(2*MUL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .busy       (busy),
    .done       (done),
    .store_data (store_data),
    .ovf_flag   (ovf_flag)
);

// File: tb/mac_accum_unit_bench.sv
module mac_accum_unit_bench;

    localparam logic [2:0] C_CLR = 3'd0, C_L32 = 3'd1, C_L48 = 3'd2, C_S32 = 3'd3,
                           C_S48 = 3'd4, C_MAC = 3'd5, C_DOT = 3'd6, C_RSV = 3'd7;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [47:0] ld;
        logic [47:0] x;
        logic [47:0] y;
        logic [3:0]  lat;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{C_L32, 32'h0, 32'h0, 48'h1234_8000_0001, 48'h0, 48'h0, 4'd9},
        '{C_S48, 32'h0, 32'h0, 48'h0, 48'h0, 48'h0, 4'd11},
        '{C_S32, 32'h0, 32'h0, 48'h0, 48'h0, 48'h0, 4'd7},
        '{C_CLR, 32'h0, 32'h0, 48'h0, 48'h0, 48'h0, 4'd4},
        '{C_MAC, 32'h0003_0000, 32'hFFFF_FE00, 48'h0, 48'h0, 48'h0, 4'd8},
        '{C_MAC, 32'h1234_5678, 32'h7654_321F, 48'h0, 48'h0, 48'h0, 4'd8},
        '{C_S48, 32'h0, 32'h0, 48'h0, 48'h0, 48'h0, 4'd11},
        '{C_DOT, 32'h0, 32'h0, 48'h0, 48'h8000_7FFF_0003, 48'h8000_7FFF_FFFB, 4'd6},
        '{C_S48, 32'h0, 32'h0, 48'h0, 48'h0, 48'h0, 4'd11},
        '{C_L48, 32'h0, 32'h0, 48'h8000_0000_0005, 48'h0, 48'h0, 4'd9},
        '{C_S32, 32'h0, 32'h0, 48'h0, 48'h0, 48'h0, 4'd7},
        '{C_DOT, 32'h0, 32'h0, 48'h0, 48'hFFFE_0100_0007, 48'h0003_FF00_FFF9, 4'd6},
        '{C_S48, 32'h0, 32'h0, 48'h0, 48'h0, 48'h0, 4'd11},
        '{C_S32, 32'h0, 32'h0, 48'h0, 48'h0, 48'h0, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = 3'd0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [47:0] dot_x = '0, dot_y = '0, load_data = '0;
    logic        busy, done, ovf_flag;
    logic [47:0] store_data;

    int n_checks = 0;
    int n_errors = 0;
    longint m_acc = 0;
    bit     m_ovf = 1'b0;
    logic [47:0] m_store = '0;

    always #2.5 clk = ~clk;

    mac_accum_unit u_mac_accum_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .dot_x(dot_x), .dot_y(dot_y),
        .load_data(load_data), .busy(busy), .done(done),
        .store_data(store_data), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic void m_add(input longint p);
        longint      s;
        logic [47:0] w;
        longint      ws;
        s  = m_acc + p;
        w  = s[47:0];
        ws = longint'($signed(w));
        if (ws != s) m_ovf = 1'b1;
        m_acc = ws;
    endfunction

    function automatic void model(input vec_t v);
        logic [47:0] a48;
        case (v.op)
            C_CLR: begin m_acc = 0; m_ovf = 1'b0; end
            C_L32: begin m_acc = longint'($signed(v.ld[31:0])); m_ovf = 1'b0; end
            C_L48: begin m_acc = longint'($signed(v.ld)); m_ovf = 1'b0; end
            C_S32: begin a48 = m_acc[47:0]; m_store = {16'h0, a48[31:0]}; end
            C_S48: m_store = m_acc[47:0];
            C_MAC: m_add(longint'($signed(v.a[31:8])) * longint'($signed(v.b[31:8])));
            C_DOT: for (int i = 0; i < 3; i++)
                       m_add(longint'($signed(v.x[i*16 +: 16])) * longint'($signed(v.y[i*16 +: 16])));
            default: ;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            C_CLR: return "R5 clear";
            C_L32, C_L48: return "R6 load";
            C_S32, C_S48: return "R7 store";
            C_MAC: return "R8 mac";
            default: return "R9 dot";
        endcase
    endfunction

    // Issue one command; optionally present a second command at busy cycle inj_at (R4).
    task automatic run_cmd(input vec_t v, input int inj_at, input logic [2:0] inj_op,
                           input logic [47:0] inj_ld);
        int n;
        int dones;
        int done_at;
        bit injected;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = v.op; opnd_a = v.a; opnd_b = v.b;
        dot_x = v.x; dot_y = v.y; load_data = v.ld;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0; dones = 0; done_at = 0; injected = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (k > 0) @(negedge clk);
            if (injected) begin cmd_valid = 1'b0; injected = 1'b0; end
            if (!busy) break;
            n++;
            if (done) begin dones++; done_at = n; end
            if (n == inj_at) begin
                cmd_valid = 1'b1; cmd_op = inj_op; load_data = inj_ld; injected = 1'b1;
            end
        end
        cmd_valid = 1'b0;
        model(v);
        chk("R3 latency", 48'(n), 48'(v.lat));
        chk("R3 done count", 48'(dones), 48'd1);
        chk("R3 done last", 48'(done_at), 48'(v.lat));
        chk(req_of(v.op), store_data, m_store);
        chk("R10 ovf", 48'(ovf_flag), 48'(m_ovf));
    endtask

    function automatic vec_t mk(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                                input logic [47:0] ld, input logic [3:0] lat);
        vec_t v;
        v.op = op; v.a = a; v.b = b; v.ld = ld; v.x = '0; v.y = '0; v.lat = lat;
        return v;
    endfunction

    initial begin
        #100000;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 busy", 48'(busy), 48'd0);
        chk("R1 done", 48'(done), 48'd0);
        chk("R1 ovf", 48'(ovf_flag), 48'd0);
        chk("R1 store", store_data, 48'd0);
        rst_n = 1'b1;
        @(negedge clk);
        run_cmd(mk(C_S48, 0, 0, 0, 4'd11), 0, 3'd0, 48'h0);   // R1 accumulator zero

        // vector table
        for (int i = 0; i < NV; i++) run_cmd(VECS[i], 0, 3'd0, 48'h0);

        // R2 reserved opcode ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = C_RSV;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk("R2 reserved busy", 48'(busy), 48'd0);
            @(negedge clk);
        end

        // R4 command mid-run and on the done cycle are ignored
        run_cmd(mk(C_CLR, 0, 0, 0, 4'd4), 2, C_L48, 48'h0000_1111_2222);
        run_cmd(mk(C_S48, 0, 0, 0, 4'd11), 11, C_L48, 48'h0000_3333_4444);
        run_cmd(mk(C_S48, 0, 0, 0, 4'd11), 0, 3'd0, 48'h0);
        chk("R4 acc untouched", store_data, 48'h0);

        // R10 wrap and sticky overflow, R5 clear resets it
        run_cmd(mk(C_L48, 0, 0, 48'h7FFF_FFFF_FFFF, 4'd9), 0, 3'd0, 48'h0);
        run_cmd(mk(C_MAC, 32'h7FFF_FF00, 32'h7FFF_FF00, 0, 4'd8), 0, 3'd0, 48'h0);
        chk("R10 ovf set", 48'(ovf_flag), 48'd1);
        run_cmd(mk(C_S48, 0, 0, 0, 4'd11), 0, 3'd0, 48'h0);
        chk("R10 wrapped", store_data, 48'h7FFF_FFFF_FFFF + 48'h3FFF_FF00_0001);
        run_cmd(mk(C_MAC, 32'h0000_0100, 32'h0000_0100, 0, 4'd8), 0, 3'd0, 48'h0);
        chk("R10 sticky", 48'(ovf_flag), 48'd1);
        run_cmd(mk(C_CLR, 0, 0, 0, 4'd4), 0, 3'd0, 48'h0);
        chk("R5 clear ovf", 48'(ovf_flag), 48'd0);
        run_cmd(mk(C_L32, 0, 0, 48'h0000_FFFF_FFFE, 4'd9), 0, 3'd0, 48'h0);
        run_cmd(mk(C_S48, 0, 0, 0, 4'd11), 0, 3'd0, 48'h0);
        chk("R6 sign extend", store_data, 48'hFFFF_FFFF_FFFE);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule